// File: doc/BRIEF.md
# Erased Sector Detector

This block runs when the ECC decoder has marked a sector as uncorrectable. It decides whether the sector is in fact an erased page that was never programmed. The sector arrives one byte per accepted beat on a valid/byte stream. A start pulse opens each sector. The first `DATA_BYTES` accepted bytes are data, and the bytes after them are the sector's stored ECC bytes, with a marker on the final ECC byte. The default sector is 512 data bytes and 13 ECC bytes.

For each stream the block counts the bits that read as zero, which are the programmed bits. Each count stops growing once it passes the correction limit, so the counters stay narrow. The verdict uses the sum of both counts. If that sum is within the limit, the sector is reported as erased, and the number of zero bits found in the data alone is returned as the correction count. The block also asks the consumer to overwrite the data with all ones when that count is nonzero. If the sum is above the limit, the sector is confirmed uncorrectable.

The verdict is registered. It appears one clock after the final ECC byte, together with a one-cycle done strobe, and it holds until the next verdict.

Top module: `blank_sector_judge`

## Requirements
- R1: While reset is asserted and after its release, `done_o`, `erased_o`, `uncorrectable_o` and `force_ones_o` are 0 and `flip_count_o` is 0 until the first verdict.
- R2: A byte is accepted only in a cycle with `in_valid_i` high. After `start_i`, the first `DATA_BYTES` accepted bytes count as data and the following ones count as ECC. A byte accepted in the same cycle as `start_i` is the first data byte of the new sector.
- R3: Each accepted byte adds to its stream's count the number of its bits that are 0.
- R4: A stream count never wraps. Once it exceeds `LIMIT` it stops accumulating, so a sector with any number of zero bits above the limit is never judged erased.
- R5: `done_o` is high for exactly one cycle, in the cycle after a byte is accepted with `in_ecc_last_i` high. `in_ecc_last_i` with `in_valid_i` low has no effect.
- R6: The verdict is erased exactly when the data zero count plus the ECC zero count is at most `LIMIT` (8 by default). A sum of 8 is erased and a sum of 9 is not.
- R7: `force_ones_o` is 1 exactly when the verdict is erased and the data zero count is nonzero.
- R8: `flip_count_o` equals the data zero count when the verdict is erased and is 0 otherwise. Zeros in the ECC bytes never add to it.
- R9: `uncorrectable_o` is 1 exactly when the verdict is not erased. At each verdict exactly one of `erased_o` and `uncorrectable_o` is 1.
- R10: `erased_o`, `uncorrectable_o`, `force_ones_o` and `flip_count_o` keep their values in every cycle without `done_o`.
- R11: `start_i` clears both counts, so an abandoned partial sector has no effect on the verdict for the next sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Opens a new sector and clears both counts |
| in_valid_i | input | 1 | Byte on `in_byte_i` is accepted this cycle |
| in_byte_i | input | BYTE_W | Sector byte, data first and then ECC |
| in_ecc_last_i | input | 1 | Marks the accepted byte as the final ECC byte |
| done_o | output | 1 | One-cycle strobe: a new verdict is on the outputs |
| erased_o | output | 1 | Sector judged erased |
| uncorrectable_o | output | 1 | Sector confirmed uncorrectable |
| force_ones_o | output | 1 | Consumer must rewrite the data as all ones |
| flip_count_o | output | CNT_W | Data zero bits reported as corrected |

## Verification
The hardest situation to reach is the one where saturation matters. Only a sector with far more zero bits than the counter width can hold would show a wrapping count. The bench therefore sends whole sectors of 0x00 data, which a wrapping count would misjudge as erased. The bench also sweeps the data zero count and the ECC zero count independently across the erase boundary. It inserts idle gaps that carry a zero byte and a stray last marker with valid low, and it abandons a sector of zeros part way through before starting a clean one.

// File: rtl/bsj_pkg.sv
package bsj_pkg;

   localparam int STREAM_DATA = 0;
   localparam int STREAM_ECC  = 1;
   localparam int NUM_STREAMS = 2;

   typedef struct packed {
      logic erased;
      logic uncorr;
      logic force_ones;
   } verdict_t;

endpackage

// File: rtl/bsj_position_track.sv
module bsj_position_track #(
   parameter int DATA_BYTES = 512,
   parameter int ECC_BYTES  = 13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic valid_i,
   output logic is_ecc_o
);
   localparam int TOTAL = DATA_BYTES + ECC_BYTES;
   localparam int POS_W = $clog2(TOTAL + 1);

   logic [POS_W-1:0] idx_q;
   logic [POS_W-1:0] cur_idx;
   logic [POS_W-1:0] idx_next;

   // the start cycle's byte sits at position zero of the new sector
   always_comb begin
      cur_idx  = start_i ? '0 : idx_q;
      is_ecc_o = (cur_idx >= POS_W'(DATA_BYTES));
      idx_next = cur_idx;
      if (valid_i && (cur_idx != POS_W'(TOTAL))) begin
         idx_next = cur_idx + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else begin
         idx_q <= idx_next;
      end
   end

endmodule

// File: rtl/bsj_zero_tally.sv
module bsj_zero_tally #(
   parameter int BYTE_W   = 8,
   parameter int LIMIT    = 8,
   parameter int CNT_W    = 5,
   parameter int POP_TREE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              en_i,
   input  logic [BYTE_W-1:0] byte_i,
   output logic [CNT_W-1:0]  cnt_next_o
);
   localparam int POP_W = $clog2(BYTE_W + 1);

   if ((POP_TREE != 0) && ((BYTE_W % 4) != 0)) begin : g_bad_tree
      $error("nibble popcount needs BYTE_W to be a multiple of 4");
   end

   logic [POP_W-1:0] zeros;

   if (POP_TREE != 0) begin : g_tree
      localparam int NIBS = BYTE_W / 4;
      logic [2:0] nib_z [NIBS];
      for (genvar n = 0; n < NIBS; n++) begin : g_nib
         assign nib_z[n] = 3'(~byte_i[4*n])   + 3'(~byte_i[4*n+1]) +
                           3'(~byte_i[4*n+2]) + 3'(~byte_i[4*n+3]);
      end
      always_comb begin
         zeros = '0;
         for (int n = 0; n < NIBS; n++) begin
            zeros = zeros + POP_W'(nib_z[n]);
         end
      end
   end else begin : g_flat
      always_comb begin
         zeros = '0;
         for (int b = 0; b < BYTE_W; b++) begin
            zeros = zeros + POP_W'(~byte_i[b]);
         end
      end
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] base;

   // once the count is past LIMIT it freezes; max value LIMIT + BYTE_W
   always_comb begin
      base       = clr_i ? '0 : cnt_q;
      cnt_next_o = base;
      if (en_i && (base <= CNT_W'(LIMIT))) begin
         cnt_next_o = base + CNT_W'(zeros);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_next_o;
      end
   end

endmodule

// File: rtl/bsj_verdict.sv
module bsj_verdict
   import bsj_pkg::*;
#(
   parameter int LIMIT = 8,
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire_i,
   input  logic [CNT_W-1:0] data_cnt_i,
   input  logic [CNT_W-1:0] ecc_cnt_i,
   output logic             done_o,
   output verdict_t         verdict_o,
   output logic [CNT_W-1:0] flips_o
);
   logic [CNT_W:0] total;
   logic           blank;
   verdict_t       next_v;

   always_comb begin
      total             = {1'b0, data_cnt_i} + {1'b0, ecc_cnt_i};
      blank             = (total <= (CNT_W + 1)'(LIMIT));
      next_v.erased     = blank;
      next_v.uncorr     = !blank;
      next_v.force_ones = blank && (data_cnt_i != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o    <= 1'b0;
         verdict_o <= '0;
         flips_o   <= '0;
      end else begin
         done_o <= fire_i;
         if (fire_i) begin
            verdict_o <= next_v;
            flips_o   <= blank ? data_cnt_i : '0;
         end
      end
   end

endmodule

// File: rtl/blank_sector_judge.sv
module blank_sector_judge
   import bsj_pkg::*;
#(
   parameter int BYTE_W     = 8,
   parameter int DATA_BYTES = 512,
   parameter int ECC_BYTES  = 13,
   parameter int LIMIT      = 8,
   parameter int POP_TREE   = 0,
   parameter int CNT_W      = $clog2(LIMIT + BYTE_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              in_valid_i,
   input  logic [BYTE_W-1:0] in_byte_i,
   input  logic              in_ecc_last_i,
   output logic              done_o,
   output logic              erased_o,
   output logic              uncorrectable_o,
   output logic              force_ones_o,
   output logic [CNT_W-1:0]  flip_count_o
);
   localparam int MIN_CNT_W = $clog2(LIMIT + BYTE_W + 1);

   if (CNT_W < MIN_CNT_W) begin : g_bad_cnt
      $error("CNT_W too narrow for LIMIT + BYTE_W");
   end
   if (LIMIT < 1) begin : g_bad_limit
      $error("LIMIT must be at least 1");
   end
   if ((DATA_BYTES < 1) || (ECC_BYTES < 1)) begin : g_bad_len
      $error("sector needs data and ECC bytes");
   end

   logic             is_ecc;
   logic [CNT_W-1:0] cnt_next [NUM_STREAMS];
   verdict_t         verdict;

   bsj_position_track #(
      .DATA_BYTES (DATA_BYTES),
      .ECC_BYTES  (ECC_BYTES)
   ) pos_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .valid_i  (in_valid_i),
      .is_ecc_o (is_ecc)
   );

   for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
      logic take;
      assign take = in_valid_i && (is_ecc == (s == STREAM_ECC));
      bsj_zero_tally #(
         .BYTE_W   (BYTE_W),
         .LIMIT    (LIMIT),
         .CNT_W    (CNT_W),
         .POP_TREE (POP_TREE)
      ) tally_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .clr_i      (start_i),
         .en_i       (take),
         .byte_i     (in_byte_i),
         .cnt_next_o (cnt_next[s])
      );
   end

   bsj_verdict #(
      .LIMIT (LIMIT),
      .CNT_W (CNT_W)
   ) verdict_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire_i     (in_valid_i && in_ecc_last_i),
      .data_cnt_i (cnt_next[STREAM_DATA]),
      .ecc_cnt_i  (cnt_next[STREAM_ECC]),
      .done_o     (done_o),
      .verdict_o  (verdict),
      .flips_o    (flip_count_o)
   );

   assign erased_o        = verdict.erased;
   assign uncorrectable_o = verdict.uncorr;
   assign force_ones_o    = verdict.force_ones;

endmodule

// File: rtl/bsj_checker.sv
module bsj_checker #(
   parameter int LIMIT = 8,
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid_i,
   input logic             in_ecc_last_i,
   input logic             done_o,
   input logic             erased_o,
   input logic             uncorrectable_o,
   input logic             force_ones_o,
   input logic [CNT_W-1:0] flip_count_o
);

   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid_i && in_ecc_last_i) |=> done_o); // R5

   AST_DONE_NEEDS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(in_valid_i && in_ecc_last_i)); // R5

   AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (erased_o != uncorrectable_o)); // R9

   AST_FORCE_NEEDS_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
      force_ones_o |-> (erased_o && (flip_count_o != '0))); // R7

   AST_FLIPS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      erased_o |-> (flip_count_o <= CNT_W'(LIMIT))); // R8

   AST_UNCORR_NO_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
      uncorrectable_o |-> (flip_count_o == '0)); // R8

   AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable({erased_o, uncorrectable_o, force_ones_o, flip_count_o})); // R10

endmodule

bind blank_sector_judge bsj_checker #(
   .LIMIT (LIMIT),
   .CNT_W (CNT_W)
) chk_i (
   .clk             (clk),
   .rst_n           (rst_n),
   .in_valid_i      (in_valid_i),
   .in_ecc_last_i   (in_ecc_last_i),
   .done_o          (done_o),
   .erased_o        (erased_o),
   .uncorrectable_o (uncorrectable_o),
   .force_ones_o    (force_ones_o),
   .flip_count_o    (flip_count_o)
);

// File: tb/blank_sector_judge_tb.sv
`timescale 1ns/1ps
module blank_sector_judge_tb_top;
   localparam int DB    = 16;
   localparam int EB    = 3;
   localparam int LIM   = 8;
   localparam int CW    = 5;
   localparam int TOT   = DB + EB;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          in_valid_i = 1'b0;
   logic [7:0]    in_byte_i = 8'h00;
   logic          in_ecc_last_i = 1'b0;
   logic          done_o, erased_o, uncorrectable_o, force_ones_o;
   logic [CW-1:0] flip_count_o;

   always #4 clk = ~clk;

   blank_sector_judge #(
      .BYTE_W (8), .DATA_BYTES (DB), .ECC_BYTES (EB),
      .LIMIT (LIM), .POP_TREE (1), .CNT_W (CW)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .start_i (start_i),
      .in_valid_i (in_valid_i), .in_byte_i (in_byte_i),
      .in_ecc_last_i (in_ecc_last_i), .done_o (done_o),
      .erased_o (erased_o), .uncorrectable_o (uncorrectable_o),
      .force_ones_o (force_ones_o), .flip_count_o (flip_count_o)
   );

   int total = 0;
   int bad = 0;
   bit finished = 0;
   logic [7:0] sec_d [DB];
   logic [7:0] sec_e [EB];

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wrap_up();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   function automatic int zc(input logic [7:0] b);
      int z = 0;
      for (int i = 0; i < 8; i++) if (!b[i]) z++;
      return z;
   endfunction

   task automatic fill_clean();
      for (int i = 0; i < DB; i++) sec_d[i] = 8'hFF;
      for (int i = 0; i < EB; i++) sec_e[i] = 8'hFF;
   endtask

   // R2: gaps carry a 0x00 byte and a stray last marker with valid low
   task automatic drive_sector(input int gap_every);
      for (int i = 0; i < TOT; i++) begin
         @(negedge clk);
         start_i       = (i == 0);
         in_valid_i    = 1'b1;
         in_byte_i     = (i < DB) ? sec_d[i] : sec_e[i-DB];
         in_ecc_last_i = (i == TOT-1);
         if (gap_every > 0 && (i % gap_every) == gap_every-1 && i != TOT-1) begin
            @(negedge clk);
            start_i = 1'b0; in_valid_i = 1'b0; in_byte_i = 8'h00; in_ecc_last_i = 1'b1;
            @(negedge clk);
            chk("R5", done_o, 0);
            in_ecc_last_i = 1'b0;
         end
      end
   endtask

   task automatic finish_sector();
      int d = 0, e = 0, er, fl, fo;
      for (int i = 0; i < DB; i++) d += zc(sec_d[i]);
      for (int i = 0; i < EB; i++) e += zc(sec_e[i]);
      er = (d + e <= LIM) ? 1 : 0;
      fl = er ? d : 0;
      fo = (er && d != 0) ? 1 : 0;
      @(negedge clk);
      start_i = 1'b0; in_valid_i = 1'b0; in_ecc_last_i = 1'b0; in_byte_i = 8'h00;
      chk("R5", done_o, 1);
      chk("R6", erased_o, er);
      chk("R9", uncorrectable_o, 1 - er);
      chk("R7", force_ones_o, fo);
      chk("R8", flip_count_o, fl);
      @(negedge clk);
      chk("R5", done_o, 0);
      chk("R10", {erased_o, uncorrectable_o, force_ones_o}, {er[0], ~er[0], fo[0]});
      chk("R10", flip_count_o, fl);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      wrap_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", {done_o, erased_o, uncorrectable_o, force_ones_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", {done_o, erased_o, uncorrectable_o, force_ones_o}, 0);
      chk("R1", flip_count_o, 0);

      // R2: zeros only in the byte that rides with start
      fill_clean(); sec_d[0] = 8'hF0;
      drive_sector(0); finish_sector();
      chk("R2", flip_count_o, 4);

      // R6 R8: sweep data and ECC zero counts across the boundary
      for (int dz = 0; dz <= 10; dz++) begin
         for (int ez = 0; ez <= 10; ez++) begin
            fill_clean();
            for (int k = 0; k < dz; k++) sec_d[k % DB][(k / DB) % 8] = 1'b0;
            for (int k = 0; k < ez; k++) sec_e[k % EB][(k / EB) % 8] = 1'b0;
            drive_sector(((dz + ez) % 4 == 0) ? 5 : 0);
            finish_sector();
         end
      end

      // R3: irregular byte patterns
      for (int n = 0; n < 40; n++) begin
         fill_clean();
         for (int i = 0; i < TOT; i++) begin
            automatic int unsigned r = $urandom;
            automatic logic [7:0] b = 8'hFF;
            if (r % 7 == 0) b = ~(8'h01 << ((r >> 4) % 8));
            else if (r % 23 == 0) b = r[15:8];
            if (i < DB) sec_d[i] = b; else sec_e[i-DB] = b;
         end
         drive_sector(n % 3 == 0 ? 4 : 0);
         finish_sector();
         chk("R3", total > 0, 1);
      end

      // R4: every data bit zero, far beyond the counter range
      fill_clean();
      for (int i = 0; i < DB; i++) sec_d[i] = 8'h00;
      drive_sector(0); finish_sector();
      chk("R4", erased_o, 0);
      chk("R4", uncorrectable_o, 1);
      for (int i = 0; i < EB; i++) sec_e[i] = 8'h00;
      drive_sector(3); finish_sector();
      chk("R4", erased_o, 0);

      // R11: abandon a sector full of zeros, then a clean one
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         start_i = (i == 0); in_valid_i = 1'b1; in_byte_i = 8'h00; in_ecc_last_i = 1'b0;
      end
      fill_clean(); sec_d[3] = 8'hF8;
      drive_sector(0); finish_sector();
      chk("R11", erased_o, 1);
      chk("R11", flip_count_o, 3);

      wrap_up();
   end
endmodule